// File: doc/BRIEF.md
# Debug Port JTAG Scan Controller

This block is the scan side of a debug port. It watches a four-wire test clock interface (clock, mode select, serial data in, serial data out) plus a synchronous active-high reset. It walks the standard sixteen-state test access port sequence, holds a 4-bit instruction, and routes the serial path through one of five data registers: a single-bit pass-through, a fixed 32-bit identification word, two 35-bit access registers (one for the debug port, one for the access port), and a 35-bit abort register.

On the chip side it issues one-cycle requests that carry a 2-bit register address, a read/write flag, a port select and 32 bits of write data. It also fires a one-cycle abort pulse. The downstream logic reports busy and returns read data. When an access register is captured, the block samples the downstream read data together with a 3-bit acknowledge. The acknowledge is WAIT while downstream is busy, and a request made during WAIT is dropped, so the host must retry it. Bank selection for access-port registers happens downstream; this block only forwards the two address bits.

Everything runs on the test clock. Serial input is taken on the rising edge, and the serial output changes on the falling edge.

Top module: `dbg_scan_port`

## Requirements
- R1: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and in that state the instruction becomes 4'b1110 (identification). `rst` high has the same effect.
- R2: Capture-IR loads 4'b0001. The instruction shifts LSB first and takes effect at Update-IR.
- R3: Instruction 4'b1110 selects a 32-bit register that captures 32'h3BA00477 and shifts it out LSB first.
- R4: Instruction 4'b1111, and every opcode other than 1110, 1010, 1011 and 1000, selects a 1-bit pass-through that captures 0. Through it `tdo` repeats `tdi` one clock later.
- R5: Instruction 4'b1010 selects the 35-bit debug-port access register. Shift-in bit 0 is the read flag (1 = read), bits 2:1 are the address and bits 34:3 are the write data. After an Update-DR with OK captured, `req_valid` is high for exactly the one cycle that follows the Update-DR edge, with `req_ap`=0.
- R6: Instruction 4'b1011 selects the access-port access register. It has the same layout and timing as R5, but with `req_ap`=1.
- R7: Capture-DR on either access register loads bits 2:0 with 3'b010 (OK) when `rsp_busy` is low and with 3'b001 (WAIT) when it is high. Bits 34:3 are loaded with `rsp_rdata`. No other acknowledge code is produced.
- R8: When WAIT was captured, the following Update-DR issues no request.
- R9: Instruction 4'b1000 selects the 35-bit abort register. An Update-DR with shifted bit 0 = 1 gives a one-cycle `abort_pulse` whatever `rsp_busy` is. With bit 0 = 0 no pulse is given, and bits 34:1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (forces Test-Logic-Reset) |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| req_valid | output | 1 | One-cycle access request strobe |
| req_ap | output | 1 | 1 = access-port request, 0 = debug-port request |
| req_addr | output | 2 | Register address bits 3:2 |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | 32 | Write data |
| abort_pulse | output | 1 | One-cycle abort strobe |
| rsp_busy | input | 1 | Downstream busy; selects WAIT at capture |
| rsp_rdata | input | 32 | Downstream read data, sampled at capture |

## Verification
The first captured bit appears on `tdo` at the falling edge after the Capture-DR (or Capture-IR) rising edge. Each later bit appears one falling edge after each Shift rising edge. The bench therefore samples `tdo` one nanosecond after every falling edge, before it drives the next `tms`/`tdi`. The request strobe and the abort pulse are registered at the Update-DR rising edge. They are checked one nanosecond after that edge, and checked again as low one clock later. WAIT and the dropped request are checked on the same scan: the acknowledge comes out during shift, and the missing strobe is observed in the cycle after the update edge.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

  typedef enum logic [3:0] {
    TS_RESET   = 4'h0,
    TS_IDLE    = 4'h1,
    TS_SEL_DR  = 4'h2,
    TS_CAP_DR  = 4'h3,
    TS_SH_DR   = 4'h4,
    TS_EX1_DR  = 4'h5,
    TS_PAU_DR  = 4'h6,
    TS_EX2_DR  = 4'h7,
    TS_UPD_DR  = 4'h8,
    TS_SEL_IR  = 4'h9,
    TS_CAP_IR  = 4'hA,
    TS_SH_IR   = 4'hB,
    TS_EX1_IR  = 4'hC,
    TS_PAU_IR  = 4'hD,
    TS_EX2_IR  = 4'hE,
    TS_UPD_IR  = 4'hF
  } tap_state_t;

  typedef enum logic [2:0] {
    DS_BYP, DS_ID, DS_DPA, DS_APA, DS_ABT
  } dr_sel_t;

  localparam int unsigned OP_W = 4;
  localparam logic [OP_W-1:0] OP_BYP = 4'b1111;
  localparam logic [OP_W-1:0] OP_ID  = 4'b1110;
  localparam logic [OP_W-1:0] OP_DPA = 4'b1010;
  localparam logic [OP_W-1:0] OP_APA = 4'b1011;
  localparam logic [OP_W-1:0] OP_ABT = 4'b1000;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      default:   return m ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
  import dbg_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge clk) begin
    if (rst) state <= TS_RESET;
    else     state <= tap_next(state, tms);
  end

endmodule

// File: rtl/dbg_ir_reg.sv
module dbg_ir_reg
  import dbg_scan_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] RESET_OP = 4'b1110
) (
  input  logic            clk,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sr <= '0;
    end else begin
      case (state)
        TS_CAP_IR: ir_sr <= CAP_VAL;
        TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:   ir_sr <= ir_sr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state == TS_RESET) ir_q <= RESET_OP;
    else if (state == TS_UPD_IR)  ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

endmodule

// File: rtl/dbg_dr_chain.sv
module dbg_dr_chain
  import dbg_scan_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h3BA00477
) (
  input  logic              clk,
  input  logic              rst,
  input  tap_state_t        state,
  input  logic [OP_W-1:0]   ir_q,
  input  logic              tdi,
  input  logic              rsp_busy,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              dr_so,
  output logic              req_valid,
  output logic              req_ap,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse
);

  localparam int unsigned ACK_W = 3;
  localparam int unsigned ACC_W = DATA_W + ADDR_W + 1;
  localparam int unsigned CH_W  = (ACC_W > ID_W) ? ACC_W : ID_W;
  localparam int unsigned LEN_W = $clog2(CH_W + 1);

  dr_sel_t          sel;
  logic [LEN_W-1:0] dr_len;
  logic [CH_W-1:0]  sr, sr_shift, cap_val;
  logic [CH_W:0]    sr_ext;
  logic             cap_ok;

  always_comb begin
    case (ir_q)
      OP_ID:   sel = DS_ID;
      OP_DPA:  sel = DS_DPA;
      OP_APA:  sel = DS_APA;
      OP_ABT:  sel = DS_ABT;
      default: sel = DS_BYP;
    endcase
  end

  always_comb begin
    case (sel)
      DS_ID:                  dr_len = LEN_W'(ID_W);
      DS_DPA, DS_APA, DS_ABT: dr_len = LEN_W'(ACC_W);
      default:                dr_len = LEN_W'(1);
    endcase
  end

  always_comb begin
    cap_val = '0;
    case (sel)
      DS_ID: cap_val[ID_W-1:0] = ID_VAL;
      DS_DPA, DS_APA: begin
        cap_val[ACK_W-1:0]            = rsp_busy ? ACK_WAIT : ACK_OK;
        cap_val[ACK_W +: DATA_W]      = rsp_rdata;
      end
      default: cap_val = '0;
    endcase
  end

  assign sr_ext = {1'b0, sr};

  generate
    for (genvar i = 0; i < CH_W; i++) begin : g_cell
      always_comb begin
        if (i == int'(dr_len) - 1)     sr_shift[i] = tdi;
        else if (i < int'(dr_len) - 1) sr_shift[i] = sr_ext[i+1];
        else                           sr_shift[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cap_ok <= 1'b0;
    end else begin
      case (state)
        TS_CAP_DR: begin
          sr     <= cap_val;
          cap_ok <= !rsp_busy;
        end
        TS_SH_DR: sr <= sr_shift;
        default:  sr <= sr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_ap      <= 1'b0;
      req_addr    <= '0;
      req_rnw     <= 1'b0;
      req_wdata   <= '0;
      abort_pulse <= 1'b0;
    end else begin
      req_valid   <= 1'b0;
      abort_pulse <= 1'b0;
      if (state == TS_UPD_DR) begin
        case (sel)
          DS_DPA, DS_APA: begin
            if (cap_ok) begin
              req_valid <= 1'b1;
              req_ap    <= (sel == DS_APA);
              req_rnw   <= sr[0];
              req_addr  <= sr[1 +: ADDR_W];
              req_wdata <= sr[ACK_W +: DATA_W];
            end
          end
          DS_ABT:  abort_pulse <= sr[0];
          default: ;
        endcase
      end
    end
  end

  assign dr_so = sr[0];

endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_scan_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h3BA00477
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              req_valid,
  output logic              req_ap,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rnw,
  output logic [DATA_W-1:0] req_wdata,
  output logic              abort_pulse,
  input  logic              rsp_busy,
  input  logic [DATA_W-1:0] rsp_rdata
);

  tap_state_t      st;
  logic [OP_W-1:0] ir_q;
  logic            ir_so, dr_so;

  dbg_tap_ctrl u_tap (
    .clk(tck), .rst(rst), .tms(tms), .state(st)
  );

  dbg_ir_reg #(.IR_W(OP_W), .RESET_OP(OP_ID)) u_ir (
    .clk(tck), .rst(rst), .state(st), .tdi(tdi), .ir_q(ir_q), .ir_so(ir_so)
  );

  dbg_dr_chain #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .ID_VAL(ID_VAL)
  ) u_dr (
    .clk(tck), .rst(rst), .state(st), .ir_q(ir_q), .tdi(tdi),
    .rsp_busy(rsp_busy), .rsp_rdata(rsp_rdata), .dr_so(dr_so),
    .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
    .req_rnw(req_rnw), .req_wdata(req_wdata), .abort_pulse(abort_pulse)
  );

  always_ff @(negedge tck) begin
    if (rst)                tdo <= 1'b0;
    else if (st == TS_SH_DR) tdo <= dr_so;
    else if (st == TS_SH_IR) tdo <= ir_so;
    else                    tdo <= 1'b0;
  end

endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk
  import dbg_scan_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      st,
  input logic [OP_W-1:0] ir_q,
  input logic            req_valid,
  input logic            abort_pulse
);

  logic [2:0] ones;

  always_ff @(posedge tck) begin
    if (rst)            ones <= '0;
    else if (!tms)      ones <= '0;
    else if (ones != 5) ones <= ones + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (rst)
    (ones == 3'd5) |-> (st == TS_RESET)); // R1

  AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (rst)
    (st == TS_RESET) |=> (ir_q == OP_ID)); // R1

  AST_REQ_AFTER_UPDATE: assert property (@(posedge tck) disable iff (rst)
    req_valid |-> ($past(st) == TS_UPD_DR)); // R5

  AST_REQ_SINGLE: assert property (@(posedge tck) disable iff (rst)
    req_valid |=> !req_valid); // R5

  AST_ABORT_SINGLE: assert property (@(posedge tck) disable iff (rst)
    abort_pulse |=> !abort_pulse); // R9

  AST_ABORT_AFTER_UPDATE: assert property (@(posedge tck) disable iff (rst)
    abort_pulse |-> ($past(st) == TS_UPD_DR && $past(ir_q) == OP_ABT)); // R9

endmodule

bind dbg_scan_port dbg_scan_port_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .st(st), .ir_q(ir_q),
  .req_valid(req_valid), .abort_pulse(abort_pulse)
);

// File: tb/sim_dbg_scan_port.sv
module sim_dbg_scan_port;

  logic        tck = 1'b0;
  logic        rst = 1'b1;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        req_valid, req_ap, req_rnw, abort_pulse;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_busy = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 tck = ~tck;

  dbg_scan_port u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
    .req_rnw(req_rnw), .req_wdata(req_wdata), .abort_pulse(abort_pulse),
    .rsp_busy(rsp_busy), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  // Idle -> scan len bits through DR -> Update-DR (ends just after update edge)
  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] iout);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o);
      iout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic idle_step();
    logic o;
    step(1'b0, 1'b0, o);
  endtask

  task automatic t_reset_id();
    logic [63:0] d;
    chk("R1 reset tdo", {63'b0, tdo}, 64'd0);
    chk("R1 reset req_valid", {63'b0, req_valid}, 64'd0);
    scan_dr(32, 64'h0, d);
    chk("R3 idcode after reset", d, 64'h3BA00477);
  endtask

  task automatic t_ir_capture();
    logic [3:0] io;
    load_ir(4'b1111, io);
    chk("R2 ir capture", {60'b0, io}, 64'h1);
  endtask

  task automatic t_bypass(input logic [3:0] op, input string tag);
    logic [3:0]  io;
    logic [63:0] d;
    load_ir(op, io);
    scan_dr(9, 64'h0B5, d);
    chk(tag, d, {55'b0, 8'hB5, 1'b0});
  endtask

  task automatic t_tms_reset();
    logic o;
    logic [63:0] d;
    logic [3:0]  io;
    load_ir(4'b1111, io);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    scan_dr(32, 64'h0, d);
    chk("R1 five tms high restores idcode", d, 64'h3BA00477);
  endtask

  task automatic t_access(input logic [3:0] op, input logic ap, input logic [31:0] wd,
                          input logic [1:0] ad, input logic rw, input logic [31:0] rd);
    logic [3:0]  io;
    logic [63:0] d;
    load_ir(op, io);
    rsp_busy  = 1'b0;
    rsp_rdata = rd;
    scan_dr(35, {29'b0, wd, ad, rw}, d);
    chk(ap ? "R7 ap ack ok" : "R7 dp ack ok", d[2:0], 64'b010);
    chk("R7 captured rdata", d[34:3], {32'b0, rd});
    chk(ap ? "R6 ap req_valid" : "R5 dp req_valid", {63'b0, req_valid}, 64'd1);
    chk(ap ? "R6 req_ap" : "R5 req_ap", {63'b0, req_ap}, {63'b0, ap});
    chk("R5 req fields", {req_wdata, req_addr, req_rnw}, {29'b0, wd, ad, rw});
    idle_step();
    chk("R5 req_valid one cycle", {63'b0, req_valid}, 64'd0);
  endtask

  task automatic t_wait();
    logic [3:0]  io;
    logic [63:0] d;
    load_ir(4'b1010, io);
    rsp_busy  = 1'b1;
    rsp_rdata = 32'h0F0F_1234;
    scan_dr(35, {29'b0, 32'h55AA55AA, 2'b11, 1'b0}, d);
    chk("R7 ack wait", d[2:0], 64'b001);
    chk("R8 no request on wait", {63'b0, req_valid}, 64'd0);
    idle_step();
    chk("R8 still no request", {63'b0, req_valid}, 64'd0);
    rsp_busy = 1'b0;
  endtask

  task automatic t_abort();
    logic [3:0]  io;
    logic [63:0] d;
    load_ir(4'b1000, io);
    rsp_busy = 1'b1;
    scan_dr(35, 64'h1, d);
    chk("R9 abort pulse while busy", {63'b0, abort_pulse}, 64'd1);
    chk("R9 abort no request", {63'b0, req_valid}, 64'd0);
    idle_step();
    chk("R9 abort one cycle", {63'b0, abort_pulse}, 64'd0);
    scan_dr(35, 64'h7_FFFF_FFFE, d);
    chk("R9 upper bits ignored", {63'b0, abort_pulse}, 64'd0);
    rsp_busy = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge tck);
    #1 rst = 1'b0;
    tms = 1'b0;
    @(posedge tck); #1;
    t_reset_id();
    t_ir_capture();
    t_bypass(4'b1111, "R4 bypass opcode");
    t_bypass(4'b0101, "R4 unlisted opcode bypass");
    t_access(4'b1010, 1'b0, 32'hCAFEF00D, 2'b10, 1'b0, 32'h12345678);
    t_access(4'b1011, 1'b1, 32'h0000_0000, 2'b01, 1'b1, 32'hDEADBEEF);
    t_wait();
    t_abort();
    t_tms_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule